// File: doc/BRIEF.md
# ADC Channel and Interrupt Register Bank

This block is the memory-mapped control and status register bank of a twelve-channel analog-to-digital converter. Software uses it to enable channels and interrupt sources, to read conversion results, and to choose which channel pairs are measured differentially. Channel enables and interrupt masks are never written directly. Each has one register where a 1 bit sets the matching state bit and another where a 1 bit clears it. A third, read-only register shows the current state.

A converter model delivers results as a channel number plus a 12-bit sample. For an enabled channel, the bank stores the sample in that channel's result slot and in a last-result register. It also raises a per-channel end-of-conversion flag and a shared data-ready flag. Reading a slot or the last-result register acknowledges the matching flag. The interrupt output is driven from the status flags gated by the mask. A control register issues one-cycle start, calibration and compare-restart strobes and a software reset of the bank.

The bus side is a plain port with separate read and write strobes and an 8-bit byte address. Read data is presented in the same cycle as the read strobe.

Top module: `adc_regbank`

## Requirements
- R1: A write to 0x10 sets every channel-enable bit n (n = 0..11) whose write-data bit n is 1, and a write to 0x14 clears those bits; other bits keep their value. Reading 0x18 returns the enable bits in [11:0]. Reads of 0x10, 0x14 and 0x00 return zero.
- R2: The interrupt mask has bit n = end-of-conversion of channel n and bit 24 = data ready. A write to 0x24 sets the mask bits written as 1, and a write to 0x28 clears them; other bit positions are never stored. Reading 0x2C returns the mask. Writing all ones to 0x28 clears the whole mask.
- R3: A result on an enabled channel n is stored in the slot at 0x50 + 4*n. It also sets status bit n and status bit 24 (status read at 0x30). A result for a disabled channel, or for a channel number of 12 or more, changes nothing.
- R4: Reading channel n's slot clears status bit n in the next cycle. If a new result for channel n arrives in the same cycle as that read, the bit stays set.
- R5: Reading 0x20 returns the most recent accepted sample in [15:0] and its channel number in [27:24]. The read clears status bit 24 unless a result is accepted in the same cycle.
- R6: Bits [27:16] of 0x4C are stored and read back, with bit 16+n belonging to channel n. When both bits of a pair (2k, 2k+1) are set, reads of that pair's slots return the sample sign-extended from bit 11 to 16 bits. The same applies to the last-result register when it holds that pair's channel. Otherwise the sample is zero-extended.
- R7: `irq` is high exactly when status AND mask is nonzero. It follows register changes in the same cycle they take effect.
- R8: Writing 0x00 with bit 1, bit 2 or bit 4 set produces a one-cycle high pulse in the following cycle on `conv_start`, `ts_calib` or `cmp_restart` respectively. At all other times these outputs are low.
- R9: Writing 0x00 with bit 0 set clears enables, mask, status, the pair field, all slots and the last-result register. A result arriving in that same cycle is dropped.
- R10: After reset every readable register reads zero. Writes to the read-only registers 0x18, 0x20, 0x2C and 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| reg_addr | input | AW (8) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| res_valid | input | 1 | Conversion result present |
| res_chan | input | CH_W (4) | Channel number of the result |
| res_data | input | RES_W (12) | Raw conversion sample |
| irq | output | 1 | Interrupt request, high while status AND mask is nonzero |
| conv_start | output | 1 | One-cycle conversion start strobe |
| ts_calib | output | 1 | One-cycle touchscreen calibration strobe |
| cmp_restart | output | 1 | One-cycle comparison restart strobe |

## Verification
The bench targets collisions between a result and an acknowledging read in the same cycle. A design that gave clear priority would lose the new end-of-conversion flag and leave `irq` low while fresh data waits.

It also checks:
- Results on disabled or out-of-range channels. A design that accepted them would overwrite a slot or raise data ready spuriously.
- Sign extension when only one bit of a pair is set, or when the pair field changes after a sample has been stored. A design that extended on a single bit, or that froze the format at capture time, would return the wrong upper nibble.
- A software reset coinciding with a result. A design that got this wrong would leave a stale flag asserting `irq` after reset.

// File: rtl/adcrb_pkg.sv
// Package: shared constants of the ADC register bank.
// Assumes byte addressing with 32-bit aligned registers.
package adcrb_pkg;
    localparam int DW          = 32;
    localparam int SLOT_W      = 16;
    localparam int DRDY_BIT    = 24;
    localparam int DIFF_LSB    = 16;
    localparam int LAST_CH_LSB = 24;

    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_EN_SET   = 8'h10;
    localparam logic [7:0] OFS_EN_CLR   = 8'h14;
    localparam logic [7:0] OFS_EN_STAT  = 8'h18;
    localparam logic [7:0] OFS_LAST     = 8'h20;
    localparam logic [7:0] OFS_IM_SET   = 8'h24;
    localparam logic [7:0] OFS_IM_CLR   = 8'h28;
    localparam logic [7:0] OFS_IM_STAT  = 8'h2C;
    localparam logic [7:0] OFS_IRQ_STAT = 8'h30;
    localparam logic [7:0] OFS_DIFF     = 8'h4C;
    localparam logic [7:0] OFS_SLOT0    = 8'h50;

    localparam int CTL_SWRST  = 0;
    localparam int CTL_START  = 1;
    localparam int CTL_CALIB  = 2;
    localparam int CTL_CMPRST = 4;
endpackage

// File: rtl/adcrb_setclr.sv
// Module: state register changed only through a set port and a clear port.
// Each port acts on the bits presented as 1.
// Assumes set and clear strobes never coincide; set is checked first.
// Bits outside KEEP are never stored.
module adcrb_setclr #(
    parameter int           W    = 12,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] q
);
    // Update the held bits from set, clear, or either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            q <= '0;
        end else if (set_we) begin
            q <= (q | wbits) & KEEP;
        end else if (clr_we) begin
            q <= q & ~wbits;
        end
    end
endmodule

// File: rtl/adcrb_results.sv
// Module: per-channel result slots, end-of-conversion flags, and the
// last-result register with its data-ready flag.
// Assumes the enable vector is the registered one. Incoming results take
// priority over acknowledging reads for the same flag. Sign handling is
// applied on the read path from chan_diff.
module adcrb_results #(
    parameter int NCH    = 12,
    parameter int RES_W  = 12,
    parameter int SLOT_W = 16,
    parameter int CH_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_rst,
    input  logic                        res_valid,
    input  logic [CH_W-1:0]             res_chan,
    input  logic [RES_W-1:0]            res_data,
    input  logic [NCH-1:0]              en,
    input  logic [NCH-1:0]              chan_diff,
    input  logic [NCH-1:0]              rd_slot,
    input  logic                        rd_last,
    output logic [NCH-1:0][SLOT_W-1:0]  slot_fmt,
    output logic [NCH-1:0]              eoc,
    output logic                        drdy,
    output logic [SLOT_W-1:0]           last_fmt,
    output logic [CH_W-1:0]             last_ch
);
    localparam int EXT_W = SLOT_W - RES_W;

    logic [NCH-1:0]            hit;
    logic                      take;
    logic [NCH-1:0][RES_W-1:0] slot_raw;
    logic [RES_W-1:0]          last_raw;
    logic                      last_diff;

    // Decode which enabled channel, if any, the incoming result belongs to.
    always_comb begin
        hit = '0;
        for (int i = 0; i < NCH; i++) begin
            hit[i] = res_valid && (res_chan == CH_W'(i)) && en[i];
        end
        take = |hit;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        // Capture the sample and track the channel's end-of-conversion flag.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst) begin
                slot_raw[n] <= '0;
                eoc[n]      <= 1'b0;
            end else if (hit[n]) begin
                slot_raw[n] <= res_data;
                eoc[n]      <= 1'b1;
            end else if (rd_slot[n]) begin
                eoc[n]      <= 1'b0;
            end
        end

        // Present the slot signed or unsigned according to its pair setting.
        always_comb begin
            if (chan_diff[n]) begin
                slot_fmt[n] = {{EXT_W{slot_raw[n][RES_W-1]}}, slot_raw[n]};
            end else begin
                slot_fmt[n] = {{EXT_W{1'b0}}, slot_raw[n]};
            end
        end
    end

    // Hold the most recent accepted sample and its data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            last_raw <= '0;
            last_ch  <= '0;
            drdy     <= 1'b0;
        end else if (take) begin
            last_raw <= res_data;
            last_ch  <= res_chan;
            drdy     <= 1'b1;
        end else if (rd_last) begin
            drdy     <= 1'b0;
        end
    end

    // Look up the pair setting of the channel held in the last-result register.
    always_comb begin
        last_diff = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (last_ch == CH_W'(i)) last_diff = chan_diff[i];
        end
        last_fmt = last_diff ? {{EXT_W{last_raw[RES_W-1]}}, last_raw}
                             : {{EXT_W{1'b0}}, last_raw};
    end
endmodule

// File: rtl/adcrb_irq.sv
// Module: assembles the interrupt status word from the flags and gates it
// with the mask.
// Assumes flag positions: channel n at bit n, data ready at DRDY_BIT.
module adcrb_irq #(
    parameter int NCH = 12
) (
    input  logic [NCH-1:0]           eoc,
    input  logic                     drdy,
    input  logic [adcrb_pkg::DW-1:0] imr,
    output logic [adcrb_pkg::DW-1:0] isr,
    output logic                     irq
);
    import adcrb_pkg::*;

    // Place the flags into the status word and reduce against the mask.
    always_comb begin
        isr           = '0;
        isr[NCH-1:0]  = eoc;
        isr[DRDY_BIT] = drdy;
        irq           = |(isr & imr);
    end
endmodule

// File: rtl/adc_regbank.sv
// Module: top of the ADC register bank. Decodes the register port, holds the
// control strobes and the pair field, and assembles read data.
// Assumes one access per cycle. Read side effects apply at the edge ending
// the read cycle. NCH <= 12 so the slots fit below 0x80.
module adc_regbank #(
    parameter int NCH   = 12,
    parameter int RES_W = 12,
    parameter int AW    = 8,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [AW-1:0]            reg_addr,
    input  logic [adcrb_pkg::DW-1:0] reg_wdata,
    output logic [adcrb_pkg::DW-1:0] reg_rdata,
    input  logic                     res_valid,
    input  logic [CH_W-1:0]          res_chan,
    input  logic [RES_W-1:0]         res_data,
    output logic                     irq,
    output logic                     conv_start,
    output logic                     ts_calib,
    output logic                     cmp_restart
);
    import adcrb_pkg::*;

    localparam int            NPAIR   = NCH / 2;
    localparam int            IDX_W   = AW - 2;
    localparam logic [DW-1:0] IM_KEEP = (DW'(1) << DRDY_BIT) | ((DW'(1) << NCH) - DW'(1));

    logic                     ctl_wr, sw_rst;
    logic                     in_win;
    logic [AW-1:0]            slot_off;
    logic [IDX_W-1:0]         slot_idx;
    logic [NCH-1:0]           rd_slot;
    logic                     rd_last;
    logic [NCH-1:0]           en_q;
    logic [DW-1:0]            msk_q;
    logic [DW-1:0]            isr_w;
    logic [NCH-1:0]           cor_q;
    logic [NCH-1:0]           chan_diff;
    logic [NCH-1:0][SLOT_W-1:0] slot_fmt;
    logic [NCH-1:0]           eoc;
    logic                     drdy;
    logic [SLOT_W-1:0]        last_fmt;
    logic [CH_W-1:0]          last_ch;

    // Decode control writes and the result-slot address window.
    always_comb begin
        ctl_wr   = reg_wr && (reg_addr == AW'(OFS_CTRL));
        sw_rst   = ctl_wr && reg_wdata[CTL_SWRST];
        slot_off = reg_addr - AW'(OFS_SLOT0);
        slot_idx = slot_off[AW-1:2];
        in_win   = (reg_addr >= AW'(OFS_SLOT0)) && (slot_off < AW'(4 * NCH))
                   && (slot_off[1:0] == 2'b00);
        rd_last  = reg_rd && (reg_addr == AW'(OFS_LAST));
        for (int i = 0; i < NCH; i++) begin
            rd_slot[i] = reg_rd && in_win && (slot_idx == IDX_W'(i));
        end
    end

    // Produce one-cycle control strobes after a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start  <= 1'b0;
            ts_calib    <= 1'b0;
            cmp_restart <= 1'b0;
        end else begin
            conv_start  <= ctl_wr && reg_wdata[CTL_START];
            ts_calib    <= ctl_wr && reg_wdata[CTL_CALIB];
            cmp_restart <= ctl_wr && reg_wdata[CTL_CMPRST];
        end
    end

    // Hold the differential pair field.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            cor_q <= '0;
        end else if (reg_wr && (reg_addr == AW'(OFS_DIFF))) begin
            cor_q <= reg_wdata[DIFF_LSB +: NCH];
        end
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign chan_diff[2*k]   = cor_q[2*k] & cor_q[2*k+1];
        assign chan_diff[2*k+1] = cor_q[2*k] & cor_q[2*k+1];
    end
    if (NCH % 2 != 0) begin : g_odd
        assign chan_diff[NCH-1] = 1'b0;
    end

    adcrb_setclr #(.W(NCH), .KEEP({NCH{1'b1}})) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .set_we (reg_wr && (reg_addr == AW'(OFS_EN_SET))),
        .clr_we (reg_wr && (reg_addr == AW'(OFS_EN_CLR))),
        .wbits  (reg_wdata[NCH-1:0]),
        .q      (en_q)
    );

    adcrb_setclr #(.W(DW), .KEEP(IM_KEEP)) u_msk (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .set_we (reg_wr && (reg_addr == AW'(OFS_IM_SET))),
        .clr_we (reg_wr && (reg_addr == AW'(OFS_IM_CLR))),
        .wbits  (reg_wdata),
        .q      (msk_q)
    );

    adcrb_results #(.NCH(NCH), .RES_W(RES_W), .SLOT_W(SLOT_W), .CH_W(CH_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data),
        .en        (en_q),
        .chan_diff (chan_diff),
        .rd_slot   (rd_slot),
        .rd_last   (rd_last),
        .slot_fmt  (slot_fmt),
        .eoc       (eoc),
        .drdy      (drdy),
        .last_fmt  (last_fmt),
        .last_ch   (last_ch)
    );

    adcrb_irq #(.NCH(NCH)) u_irq (
        .eoc  (eoc),
        .drdy (drdy),
        .imr  (msk_q),
        .isr  (isr_w),
        .irq  (irq)
    );

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_EN_STAT)) begin
            reg_rdata = DW'(en_q);
        end else if (reg_addr == AW'(OFS_IM_STAT)) begin
            reg_rdata = msk_q;
        end else if (reg_addr == AW'(OFS_IRQ_STAT)) begin
            reg_rdata = isr_w;
        end else if (reg_addr == AW'(OFS_DIFF)) begin
            reg_rdata = DW'(cor_q) << DIFF_LSB;
        end else if (reg_addr == AW'(OFS_LAST)) begin
            reg_rdata = (DW'(last_ch) << LAST_CH_LSB) | DW'(last_fmt);
        end else if (in_win) begin
            for (int i = 0; i < NCH; i++) begin
                if (slot_idx == IDX_W'(i)) reg_rdata = DW'(slot_fmt[i]);
            end
        end
    end
endmodule

// File: rtl/adcrb_chk.sv
// Module: assertion checker for adc_regbank, attached through bind.
// Assumes the top's internal en_q, msk_q and isr_w nets.
module adcrb_chk #(
    parameter int NCH  = 12,
    parameter int AW   = 8,
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_rd,
    input logic [AW-1:0]   reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [31:0]     reg_rdata,
    input logic            res_valid,
    input logic [CH_W-1:0] res_chan,
    input logic            irq,
    input logic            conv_start,
    input logic [NCH-1:0]  en_q,
    input logic [31:0]     msk_q,
    input logic [31:0]     isr_w
);
    logic ctl_wr, swr;
    assign ctl_wr = reg_wr && (reg_addr == AW'(8'h00));
    assign swr    = ctl_wr && reg_wdata[0];

    a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(8'h10) && !swr) |=> en_q == $past(en_q | reg_wdata[NCH-1:0]));

    a_r1_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(8'h14)) |=> en_q == $past(en_q & ~reg_wdata[NCH-1:0]));

    a_r1_setreg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(8'h10) || reg_addr == AW'(8'h14)) |-> reg_rdata == 32'h0);

    a_r2_mask_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(8'h28) && reg_wdata == 32'hFFFF_FFFF) |=> (msk_q == 32'h0 && !irq));

    a_r3_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_chan < CH_W'(NCH) && en_q[res_chan] && !swr)
        |=> (isr_w[$past(res_chan)] && isr_w[24]));

    a_r5_last_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == AW'(8'h20) && !res_valid) |=> !isr_w[24]);

    a_r7_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == 32'h0) |-> !irq);

    a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[1]) |=> conv_start);

    a_r8_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && reg_wdata[1]) |=> !conv_start);

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (en_q == '0 && msk_q == 32'h0 && isr_w == 32'h0));
endmodule

bind adc_regbank adcrb_chk #(.NCH(NCH), .AW(AW), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .res_valid  (res_valid),
    .res_chan   (res_chan),
    .irq        (irq),
    .conv_start (conv_start),
    .en_q       (en_q),
    .msk_q      (msk_q),
    .isr_w      (isr_w)
);

// File: tb/sim_adc_regbank.sv
// Bench: behavioural reference model compared every clock and on every read.
module sim_adc_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        res_valid = 1'b0;
    logic [3:0]  res_chan = 4'h0;
    logic [11:0] res_data = 12'h0;
    logic        irq, conv_start, ts_calib, cmp_restart;

    int total = 0, bad = 0;
    bit done = 0;
    bit live = 0;

    // Model state.
    int m_en, m_msk, m_isr, m_cor, m_last, m_lastch;
    int m_slot[12];
    bit m_start, m_cal, m_cmp;

    always #5 clk = ~clk;

    adc_regbank u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .irq(irq), .conv_start(conv_start), .ts_calib(ts_calib),
        .cmp_restart(cmp_restart)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int slot_index(input int a);
        if (a >= 'h50 && a < 'h50 + 48 && (a % 4) == 0) return (a - 'h50) / 4;
        return -1;
    endfunction

    function automatic int fmt(input int v, input int ch);
        int p = ch / 2;
        bit d = ((m_cor >> (16 + 2 * p)) & 1) && ((m_cor >> (17 + 2 * p)) & 1);
        if (d && (v & 'h800)) return v | 'hF000;
        return v;
    endfunction

    function automatic int model_read(input int a);
        int i = slot_index(a);
        if (a == 'h18) return m_en;
        if (a == 'h2C) return m_msk;
        if (a == 'h30) return m_isr;
        if (a == 'h4C) return m_cor;
        if (a == 'h20) return fmt(m_last, m_lastch) | (m_lastch << 24);
        if (i >= 0) return fmt(m_slot[i], i);
        return 0;
    endfunction

    // Reference model update at each edge.
    always @(posedge clk) begin
        int a, d, old_en, idx;
        a = reg_addr; d = reg_wdata; old_en = m_en;
        if (!rst_n) begin
            m_en = 0; m_msk = 0; m_isr = 0; m_cor = 0; m_last = 0; m_lastch = 0;
            foreach (m_slot[i]) m_slot[i] = 0;
            m_start = 0; m_cal = 0; m_cmp = 0;
        end else begin
            m_start = reg_wr && a == 0 && d[1];
            m_cal   = reg_wr && a == 0 && d[2];
            m_cmp   = reg_wr && a == 0 && d[4];
            if (reg_wr && a == 0 && d[0]) begin
                m_en = 0; m_msk = 0; m_isr = 0; m_cor = 0; m_last = 0; m_lastch = 0;
                foreach (m_slot[i]) m_slot[i] = 0;
            end else begin
                idx = slot_index(a);
                if (reg_rd && a == 'h20) m_isr &= ~(1 << 24);
                if (reg_rd && idx >= 0) m_isr &= ~(1 << idx);
                if (reg_wr) begin
                    case (a)
                        'h10: m_en  |= d & 'hFFF;
                        'h14: m_en  &= ~d;
                        'h24: m_msk |= d & 'h0100_0FFF;
                        'h28: m_msk &= ~d;
                        'h4C: m_cor  = d & 'h0FFF_0000;
                        default: ;
                    endcase
                end
                if (res_valid && res_chan < 12 && ((old_en >> res_chan) & 1)) begin
                    m_slot[res_chan] = res_data;
                    m_last = res_data;
                    m_lastch = res_chan;
                    m_isr |= (1 << res_chan) | (1 << 24);
                end
            end
        end
    end

    // Per-cycle comparison of the interrupt line and strobes.
    always @(posedge clk) begin
        #2;
        if (live && !done) begin
            chk({31'b0, irq}, {31'b0, (m_isr & m_msk) != 0}, "R7 irq");
            chk({29'b0, conv_start, ts_calib, cmp_restart},
                {29'b0, m_start, m_cal, m_cmp}, "R8 strobes");
        end
    end

    task automatic cyc(input bit w, input bit r, input int a, input int d,
                       input bit v, input int ch, input int val, input string tag);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a[7:0]; reg_wdata = d;
        res_valid = v; res_chan = ch[3:0]; res_data = val[11:0];
        #1;
        if (r) chk(reg_rdata, model_read(a), tag);
        @(posedge clk);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        cyc(1, 0, a, d, 0, 0, 0, tag);
    endtask
    task automatic rd(input int a, input string tag);
        cyc(0, 1, a, 0, 0, 0, 0, tag);
    endtask
    task automatic push(input int ch, input int val, input string tag);
        cyc(0, 0, 0, 0, 1, ch, val, tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        live = 1;
        // R10 reset values.
        foreach (m_slot[i]) rd('h50 + 4 * i, "R10 slot reset");
        rd('h18, "R10 enable reset"); rd('h2C, "R10 mask reset");
        rd('h30, "R10 status reset"); rd('h20, "R10 last reset"); rd('h4C, "R10 pair reset");
        // R1 set/clear enables.
        wr('h10, 'h00F, "R1 set"); rd('h18, "R1 enable after set");
        wr('h14, 'h002, "R1 clear"); rd('h18, "R1 enable after clear");
        rd('h10, "R1 set reg reads 0"); rd('h14, "R1 clr reg reads 0"); rd('h00, "R1 ctrl reads 0");
        // R2 mask.
        wr('h24, 'hFFFF_FFFF, "R2 set all"); rd('h2C, "R2 mask kept bits");
        wr('h28, 'hFFFF_FFFF, "R2 disable all"); rd('h2C, "R2 mask cleared");
        wr('h24, 'h0100_0005, "R2 set some"); rd('h2C, "R2 mask partial");
        // R3 accepted and ignored results.
        push(0, 'h123, "R3 push ch0"); rd('h30, "R3 status after ch0");
        rd('h50, "R3 slot ch0");
        rd('h30, "R4 eoc0 cleared by read");
        push(1, 'h456, "R3 push disabled ch1"); rd('h54, "R3 disabled slot untouched");
        push(13, 'h777, "R3 push ch13"); rd('h30, "R3 out of range ignored");
        // R5 last result acknowledge.
        rd('h20, "R5 last value"); rd('h30, "R5 drdy cleared");
        // R4 collision: read and new result on ch2 together.
        push(2, 'h0AA, "R4 first ch2");
        cyc(0, 1, 'h58, 0, 1, 2, 'h0BB, "R4 read during result");
        rd('h30, "R4 eoc2 stays set"); rd('h58, "R4 new ch2 value");
        // R6 differential pairs.
        wr('h10, 'hFFF, "R6 enable all");
        wr('h4C, 'h0007_0000, "R6 pair0 full pair1 half"); rd('h4C, "R6 pair field readback");
        push(0, 'h800, "R6 ch0"); push(1, 'h7FF, "R6 ch1"); push(2, 'h900, "R6 ch2");
        rd('h50, "R6 ch0 signed"); rd('h54, "R6 ch1 positive"); rd('h58, "R6 ch2 half pair unsigned");
        push(0, 'hF00, "R6 ch0 again"); rd('h20, "R6 last signed");
        wr('h4C, 'h0, "R6 pair off"); rd('h50, "R6 ch0 now unsigned");
        // R10 writes to read-only registers.
        wr('h18, 'h0, "R10 write enable status"); wr('h30, 'h0, "R10 write status");
        wr('h2C, 'h0, "R10 write mask status"); wr('h20, 'hFFFF, "R10 write last");
        rd('h18, "R10 enable unchanged"); rd('h30, "R10 status unchanged");
        rd('h2C, "R10 mask unchanged"); rd('h20, "R10 last unchanged");
        // R8 strobes.
        wr('h00, 'h02, "R8 start"); wr('h00, 'h04, "R8 calib"); wr('h00, 'h10, "R8 cmp");
        wr('h00, 'h16, "R8 all three");
        // R9 soft reset with a concurrent result.
        cyc(1, 0, 'h00, 'h01, 1, 3, 'h321, "R9 reset with result");
        rd('h18, "R9 enable cleared"); rd('h30, "R9 status cleared");
        rd('h5C, "R9 slot cleared"); rd('h2C, "R9 mask cleared"); rd('h20, "R9 last cleared");
        // Mixed traffic checked against the model.
        for (int k = 0; k < 600; k++) begin
            int op = $urandom_range(0, 9);
            int ch = $urandom_range(0, 15);
            int d  = $urandom;
            case (op)
                0: wr('h10, d, "R1 random set");
                1: wr('h14, d & 'h0F0, "R1 random clear");
                2: wr('h24, d, "R2 random set");
                3: wr('h28, d & 'h0100_000F, "R2 random clear");
                4: wr('h4C, d, "R6 random pair");
                5: rd('h50 + 4 * $urandom_range(0, 11), "R4 random slot read");
                6: rd('h20, "R5 random last read");
                7: rd('h30, "R3 random status read");
                8: cyc(0, 1, 'h50 + 4 * (ch % 12), 0, 1, ch, d & 'hFFF, "R4 random collision");
                default: push(ch, d & 'hFFF, "R3 random push");
            endcase
        end
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; res_valid = 0;
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end
endmodule